// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that runs a chain of transfer descriptors kept in memory. Each descriptor is read in full as eight words starting at a link address. The engine checks the valid flag in the header and loads the source address, destination address, byte count and a configuration word. It then copies the data beat by beat. When the count is used up it writes the header back with the valid flag cleared. It follows the next-link word if the descriptor asks for that. A chain may loop back on itself: the engine stops when it meets a descriptor it has already consumed.

A start pulse arms the channel at a given descriptor address and selects the trigger. With the software trigger, beats run freely, which gives memory-to-memory copies; the usual configuration for that is 0x80400008. With the peripheral trigger, every beat waits for the request input on the side that the configuration names. The memory side is a single master port with one access outstanding at a time. That port carries a valid/ready request and a one-cycle response.

The controller is a state machine with these states:
- IDLE
- FETCH and FWAIT, one word per pass
- CHECK
- GATE_RD, READ, RWAIT
- GATE_WR, WRITE, WWAIT
- RETIRE and BWAIT, for the header write-back

Transitions:
- IDLE→FETCH on start.
- FETCH→FWAIT on ready.
- FWAIT→FETCH on a response while words remain, and FWAIT→CHECK after the eighth word.
- CHECK→IDLE for an invalid header or an illegal size, CHECK→RETIRE for a zero count, and CHECK→GATE_RD otherwise.
- GATE_RD→READ when the read side is open, then READ→RWAIT→GATE_WR.
- GATE_WR→WRITE when the write side is open, then WRITE→WWAIT.
- WWAIT→GATE_RD if bytes remain, and WWAIT→RETIRE on the last beat.
- RETIRE→BWAIT on ready.
- BWAIT→FETCH when linking, and BWAIT→IDLE otherwise.
- Every wait state goes to IDLE on an error response.

Top module: `ldma_chan`

## Requirements
- R1: After start, the engine reads eight 32-bit words (size code 2) at ascending addresses base, base+4, … base+28. They are taken as header, source, destination, byte count, configuration, interval, extension and next link, in that order.
- R2: If bit 0 of the fetched header is 0, no data access is made. `busy` falls and `end_irq` pulses for one cycle, with `err` left at 0.
- R3: Configuration bits 15:12 give the source size code and bits 19:16 the destination size code; code n means 2^n bytes per beat. If the two codes differ or exceed 2, `err` is set and the channel halts with no data access.
- R4: Each beat reads at the source address and writes at the destination address. After each beat each address advances by the beat size, except the source when configuration bit 20 is 1 and the destination when bit 21 is 1.
- R5: The byte count falls by the beat size on every beat and the last beat is the one that takes it to zero or below. A count of zero moves no data.
- R6: After the last beat, the header is written back to the descriptor base with bit 0 cleared and its other bits kept. This happens before any further fetch.
- R7: When configuration bit 31 is 1, the next descriptor is fetched from the next-link word, and a ring back to an earlier descriptor is allowed. When bit 31 is 0, the channel stops after the write-back.
- R8: On completing a descriptor, `end_irq` pulses for one cycle unless configuration bit 24 is 1.
- R9: With `start_sw`=1 at start, beats run without any `periph_req` and `periph_ack` stays low.
- R10: With `start_sw`=0, configuration bit 3 = 0 makes each read wait for `periph_req`, and bit 3 = 1 makes each write wait for it. `periph_ack` pulses once for each gated access that completes.
- R11: An error response to any access sets `err`, drops `busy` and stops all further requests. The next start clears `err`.
- R12: A request is held stable until it is accepted, and only one access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arm the channel when idle |
| start_sw | input | 1 | 1: software trigger, 0: peripheral trigger |
| start_addr | input | AW | Address of the first descriptor |
| periph_req | input | 1 | Peripheral request level |
| periph_ack | output | 1 | One-cycle pulse when a gated access completes |
| busy | output | 1 | Channel enabled |
| end_irq | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Sticky error status |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 for a write |
| mem_addr | output | AW | Byte address |
| mem_size | output | 3 | Access size code (2^n bytes) |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_resp_valid | input | 1 | Response strobe |
| mem_resp_err | input | 1 | Response reports an error |
| mem_resp_data | input | 32 | Read data, right-aligned |

## Verification
On every cycle, the assertions check these rules of the memory port and the status outputs:
- a request holds still until it is accepted, and only one is ever outstanding;
- no access is made with an illegal size;
- a raised error always comes with a stopped, silent channel;
- the end pulse lasts a single cycle.

Other behaviour shows only in the directed scenarios, from the memory contents and the access log the bench keeps:
- which addresses are touched and in what order;
- fixed versus incrementing addresses;
- write-back of the header before the link fetch;
- ring termination on a consumed header;
- masking of the end pulse along a chain;
- which side of a beat waits for the peripheral request.

// File: rtl/ldma_pkg.sv
package ldma_pkg;

    localparam int WORD_BITS  = 32;
    localparam int WORD_BYTES = WORD_BITS / 8;
    localparam int WORD_SZ    = $clog2(WORD_BYTES);   // size code of a full word
    localparam int MAX_SZ     = WORD_SZ;              // widest legal beat
    localparam int DESC_WORDS = 8;
    localparam int IDX_W      = $clog2(DESC_WORDS);

    // word order inside a descriptor (behavioural: fetch sequence)
    localparam int W_HEAD = 0;
    localparam int W_SRC  = 1;
    localparam int W_DST  = 2;
    localparam int W_CNT  = 3;
    localparam int W_CFG  = 4;
    localparam int W_LINK = 7;

    // bit positions inside the configuration word
    localparam int B_REQ_DST  = 3;
    localparam int B_SSZ_LSB  = 12;
    localparam int B_DSZ_LSB  = 16;
    localparam int B_SRC_FIX  = 20;
    localparam int B_DST_FIX  = 21;
    localparam int B_END_MASK = 24;
    localparam int B_LINKED   = 31;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_FWAIT, S_CHECK,
        S_GATE_RD, S_READ, S_RWAIT,
        S_GATE_WR, S_WRITE, S_WWAIT,
        S_RETIRE, S_BWAIT
    } ldma_state_e;

    typedef struct packed {
        logic [WORD_BITS-1:0] head;
        logic [WORD_BITS-1:0] src;
        logic [WORD_BITS-1:0] dst;
        logic [WORD_BITS-1:0] count;
        logic [WORD_BITS-1:0] link;
        logic [3:0]           ssz;
        logic [3:0]           dsz;
        logic                 sfix;
        logic                 dfix;
        logic                 end_mask;
        logic                 linked;
        logic                 req_dst;
    } ldma_desc_t;

endpackage

// File: rtl/ldma_desc_store.sv
module ldma_desc_store
    import ldma_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [IDX_W-1:0]     idx,
    input  logic [WORD_BITS-1:0] word,
    output ldma_desc_t           desc
);

    ldma_desc_t desc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q <= '0;
        end else if (load) begin
            unique case (idx)
                IDX_W'(W_HEAD): desc_q.head  <= word;
                IDX_W'(W_SRC):  desc_q.src   <= word;
                IDX_W'(W_DST):  desc_q.dst   <= word;
                IDX_W'(W_CNT):  desc_q.count <= word;
                IDX_W'(W_CFG): begin
                    desc_q.ssz      <= word[B_SSZ_LSB +: 4];
                    desc_q.dsz      <= word[B_DSZ_LSB +: 4];
                    desc_q.sfix     <= word[B_SRC_FIX];
                    desc_q.dfix     <= word[B_DST_FIX];
                    desc_q.end_mask <= word[B_END_MASK];
                    desc_q.linked   <= word[B_LINKED];
                    desc_q.req_dst  <= word[B_REQ_DST];
                end
                IDX_W'(W_LINK): desc_q.link <= word;
                default: ;
            endcase
        end
    end

    assign desc = desc_q;

endmodule

// File: rtl/ldma_walker.sv
module ldma_walker
    import ldma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init,
    input  logic                 step,
    input  logic [AW-1:0]        src0,
    input  logic [AW-1:0]        dst0,
    input  logic [WORD_BITS-1:0] cnt0,
    input  logic [2:0]           sz,
    input  logic                 sfix,
    input  logic                 dfix,
    output logic [AW-1:0]        src,
    output logic [AW-1:0]        dst,
    output logic                 last
);

    logic [AW-1:0]        src_q, dst_q;
    logic [WORD_BITS-1:0] rem_q;
    logic [WORD_BITS-1:0] beat;

    assign beat = WORD_BITS'(1) << sz;
    assign last = (rem_q <= beat);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            rem_q <= '0;
        end else if (init) begin
            src_q <= src0;
            dst_q <= dst0;
            rem_q <= cnt0;
        end else if (step) begin
            if (!sfix) src_q <= src_q + AW'(beat);
            if (!dfix) dst_q <= dst_q + AW'(beat);
            rem_q <= last ? '0 : rem_q - beat;
        end
    end

    assign src = src_q;
    assign dst = dst_q;

endmodule

// File: rtl/ldma_fsm.sv
module ldma_fsm
    import ldma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 start_sw,
    input  logic [AW-1:0]        start_addr,
    input  logic                 periph_req,
    input  logic                 mem_ready,
    input  logic                 mem_resp_valid,
    input  logic                 mem_resp_err,
    input  logic [WORD_BITS-1:0] mem_resp_data,
    input  ldma_desc_t           desc,
    input  logic [AW-1:0]        src,
    input  logic [AW-1:0]        dst,
    input  logic                 last,
    output logic                 busy,
    output logic                 end_irq,
    output logic                 err,
    output logic                 periph_ack,
    output logic                 mem_valid,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [2:0]           mem_size,
    output logic [WORD_BITS-1:0] mem_wdata,
    output logic                 load,
    output logic [IDX_W-1:0]     load_idx,
    output logic                 walk_init,
    output logic                 walk_step
);

    ldma_state_e          state_q, state_d;
    logic [AW-1:0]        cur_q;
    logic [IDX_W-1:0]     idx_q;
    logic                 sw_q;
    logic                 err_q;
    logic                 end_q;
    logic                 ack_q;
    logic [WORD_BITS-1:0] data_q;

    logic resp_ok, resp_bad, size_ok, rd_open, wr_open, last_word;

    assign resp_ok   = mem_resp_valid && !mem_resp_err;
    assign resp_bad  = mem_resp_valid &&  mem_resp_err;
    assign size_ok   = (desc.ssz == desc.dsz) && (desc.ssz <= 4'(MAX_SZ));
    assign rd_open   = sw_q ||  desc.req_dst || periph_req;
    assign wr_open   = sw_q || !desc.req_dst || periph_req;
    assign last_word = (idx_q == IDX_W'(DESC_WORDS - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = S_FETCH;
            S_FETCH:   if (mem_ready) state_d = S_FWAIT;
            S_FWAIT:   if (resp_bad) state_d = S_IDLE;
                       else if (resp_ok) state_d = last_word ? S_CHECK : S_FETCH;
            S_CHECK:   if (!desc.head[0] || !size_ok) state_d = S_IDLE;
                       else if (desc.count == '0) state_d = S_RETIRE;
                       else state_d = S_GATE_RD;
            S_GATE_RD: if (rd_open) state_d = S_READ;
            S_READ:    if (mem_ready) state_d = S_RWAIT;
            S_RWAIT:   if (resp_bad) state_d = S_IDLE;
                       else if (resp_ok) state_d = S_GATE_WR;
            S_GATE_WR: if (wr_open) state_d = S_WRITE;
            S_WRITE:   if (mem_ready) state_d = S_WWAIT;
            S_WWAIT:   if (resp_bad) state_d = S_IDLE;
                       else if (resp_ok) state_d = last ? S_RETIRE : S_GATE_RD;
            S_RETIRE:  if (mem_ready) state_d = S_BWAIT;
            S_BWAIT:   if (resp_bad) state_d = S_IDLE;
                       else if (resp_ok) state_d = desc.linked ? S_FETCH : S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // channel registers updated alongside the transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            idx_q  <= '0;
            sw_q   <= 1'b0;
            err_q  <= 1'b0;
            end_q  <= 1'b0;
            ack_q  <= 1'b0;
            data_q <= '0;
        end else begin
            end_q <= 1'b0;
            ack_q <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start) begin
                    cur_q <= start_addr;
                    sw_q  <= start_sw;
                    err_q <= 1'b0;
                    idx_q <= '0;
                end
                S_FWAIT: begin
                    if (resp_bad)     err_q <= 1'b1;
                    else if (resp_ok) idx_q <= idx_q + 1'b1;
                end
                S_CHECK: begin
                    if (!desc.head[0]) end_q <= 1'b1;
                    else if (!size_ok) err_q <= 1'b1;
                end
                S_RWAIT: begin
                    if (resp_bad) err_q <= 1'b1;
                    else if (resp_ok) begin
                        data_q <= mem_resp_data;
                        if (!sw_q && !desc.req_dst) ack_q <= 1'b1;
                    end
                end
                S_WWAIT: begin
                    if (resp_bad) err_q <= 1'b1;
                    else if (resp_ok && !sw_q && desc.req_dst) ack_q <= 1'b1;
                end
                S_BWAIT: begin
                    if (resp_bad) err_q <= 1'b1;
                    else if (resp_ok) begin
                        if (!desc.end_mask) end_q <= 1'b1;
                        if (desc.linked)    cur_q <= AW'(desc.link);
                        idx_q <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_q;
        mem_size  = 3'(WORD_SZ);
        mem_wdata = data_q;
        load      = 1'b0;
        walk_init = 1'b0;
        walk_step = 1'b0;
        unique case (state_q)
            S_FETCH:  begin
                mem_valid = 1'b1;
                mem_addr  = cur_q + AW'({idx_q, 2'b00});
            end
            S_FWAIT:  load = resp_ok;
            S_CHECK:  walk_init = 1'b1;
            S_READ:   begin
                mem_valid = 1'b1;
                mem_addr  = src;
                mem_size  = desc.ssz[2:0];
            end
            S_WRITE:  begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst;
                mem_size  = desc.dsz[2:0];
            end
            S_WWAIT:  walk_step = resp_ok;
            S_RETIRE: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {desc.head[WORD_BITS-1:1], 1'b0};
            end
            default: ;
        endcase
    end

    assign load_idx   = idx_q;
    assign busy       = (state_q != S_IDLE);
    assign end_irq    = end_q;
    assign err        = err_q;
    assign periph_ack = ack_q;

endmodule

// File: rtl/ldma_chan.sv
module ldma_chan
    import ldma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 start_sw,
    input  logic [AW-1:0]        start_addr,
    input  logic                 periph_req,
    output logic                 periph_ack,
    output logic                 busy,
    output logic                 end_irq,
    output logic                 err,
    output logic                 mem_valid,
    input  logic                 mem_ready,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [2:0]           mem_size,
    output logic [WORD_BITS-1:0] mem_wdata,
    input  logic                 mem_resp_valid,
    input  logic                 mem_resp_err,
    input  logic [WORD_BITS-1:0] mem_resp_data
);

    ldma_desc_t       desc;
    logic             load, walk_init, walk_step, last;
    logic [IDX_W-1:0] load_idx;
    logic [AW-1:0]    src, dst;

    ldma_desc_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .idx   (load_idx),
        .word  (mem_resp_data),
        .desc  (desc)
    );

    ldma_walker #(.AW(AW)) u_walk (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (walk_init),
        .step  (walk_step),
        .src0  (AW'(desc.src)),
        .dst0  (AW'(desc.dst)),
        .cnt0  (desc.count),
        .sz    (desc.ssz[2:0]),
        .sfix  (desc.sfix),
        .dfix  (desc.dfix),
        .src   (src),
        .dst   (dst),
        .last  (last)
    );

    ldma_fsm #(.AW(AW)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .start_sw       (start_sw),
        .start_addr     (start_addr),
        .periph_req     (periph_req),
        .mem_ready      (mem_ready),
        .mem_resp_valid (mem_resp_valid),
        .mem_resp_err   (mem_resp_err),
        .mem_resp_data  (mem_resp_data),
        .desc           (desc),
        .src            (src),
        .dst            (dst),
        .last           (last),
        .busy           (busy),
        .end_irq        (end_irq),
        .err            (err),
        .periph_ack     (periph_ack),
        .mem_valid      (mem_valid),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_size       (mem_size),
        .mem_wdata      (mem_wdata),
        .load           (load),
        .load_idx       (load_idx),
        .walk_init      (walk_init),
        .walk_step      (walk_step)
    );

endmodule

// File: rtl/ldma_chan_sva.sv
module ldma_chan_sva
    import ldma_pkg::*;
#(
    parameter int AW = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 end_irq,
    input logic                 err,
    input logic                 mem_valid,
    input logic                 mem_ready,
    input logic                 mem_we,
    input logic [AW-1:0]        mem_addr,
    input logic [2:0]           mem_size,
    input logic [WORD_BITS-1:0] mem_wdata,
    input logic                 mem_resp_valid
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                     pend_q <= 1'b0;
        else if (mem_valid && mem_ready) pend_q <= 1'b1;
        else if (mem_resp_valid)        pend_q <= 1'b0;
    end

    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                    && $stable(mem_we) && $stable(mem_wdata)
                                    && $stable(mem_size));

    p_one_outstanding_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !mem_valid);

    p_size_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_size <= 3'(MAX_SZ));

    p_err_halts_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy && !mem_valid);

    p_end_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        end_irq |=> !end_irq);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_valid);

endmodule

bind ldma_chan ldma_chan_sva #(.AW(AW)) u_ldma_chan_sva (.*);

// File: tb/ldma_chan_bench.sv
module ldma_chan_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 32;
    localparam int MEM_WORDS  = 256;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, start_sw = 1'b0, periph_req = 1'b0;
    logic [31:0] start_addr = '0;
    logic        periph_ack, busy, end_irq, err;
    logic        mem_valid, mem_we;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata;
    logic [2:0]  mem_size;
    logic        mem_resp_valid = 1'b0, mem_resp_err = 1'b0;
    logic [31:0] mem_resp_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ldma_chan #(.AW(AW)) u_ldma_chan (.*);

    // memory model and monitors
    logic [31:0] mem [MEM_WORDS];
    logic        bd_en = 1'b0;
    logic [31:0] bd_addr = '0, bd_data = '0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic [31:0] cyc = '0;
    int          rd_n = 0, wr_n = 0, irq_n = 0, ack_n = 0, log_n = 0;
    logic [31:0] log_addr [64];
    logic        log_we   [64];

    function automatic logic [31:0] lane_rd(logic [31:0] w, logic [1:0] off, logic [2:0] sz);
        logic [31:0] s;
        s = w >> (32'(off) * 8);
        case (sz)
            3'd0:    return {24'h0, s[7:0]};
            3'd1:    return {16'h0, s[15:0]};
            default: return s;
        endcase
    endfunction

    function automatic logic [31:0] lane_wr(logic [31:0] w, logic [1:0] off, logic [2:0] sz, logic [31:0] d);
        logic [31:0] m;
        m = (sz == 3'd0) ? 32'hFF : (sz == 3'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
        m = m << (32'(off) * 8);
        return (w & ~m) | ((d << (32'(off) * 8)) & m);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '0;
            mem_resp_valid <= 1'b0;
            mem_resp_err   <= 1'b0;
            mem_ready      <= 1'b0;
            cyc            <= '0;
        end else begin
            cyc            <= cyc + 1;
            mem_ready      <= (cyc[1:0] != 2'd3);
            mem_resp_valid <= 1'b0;
            mem_resp_err   <= 1'b0;
            if (bd_en) mem[bd_addr[9:2]] <= bd_data;
            if (mem_valid && mem_ready) begin
                log_addr[log_n % 64] <= mem_addr;
                log_we[log_n % 64]   <= mem_we;
                log_n                <= log_n + 1;
                mem_resp_valid       <= 1'b1;
                if (mem_we) wr_n <= wr_n + 1;
                else        rd_n <= rd_n + 1;
                if (mem_addr == err_addr)
                    mem_resp_err <= 1'b1;
                else if (mem_we)
                    mem[mem_addr[9:2]] <= lane_wr(mem[mem_addr[9:2]], mem_addr[1:0], mem_size, mem_wdata);
                else
                    mem_resp_data <= lane_rd(mem[mem_addr[9:2]], mem_addr[1:0], mem_size);
            end
            if (end_irq)    irq_n <= irq_n + 1;
            if (periph_ack) ack_n <= ack_n + 1;
        end
    end

    int n_chk = 0, n_fail = 0;
    int s_rd, s_wr, s_irq, s_ack, s_log;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bd_en = 1'b1; bd_addr = a; bd_data = d;
        @(posedge clk); #1;
        bd_en = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] base, input logic [31:0] hd, input logic [31:0] s,
                            input logic [31:0] d, input logic [31:0] n, input logic [31:0] cfg,
                            input logic [31:0] lnk);
        poke(base,      hd);
        poke(base + 4,  s);
        poke(base + 8,  d);
        poke(base + 12, n);
        poke(base + 16, cfg);
        poke(base + 20, 32'h0);
        poke(base + 24, 32'h0);
        poke(base + 28, lnk);
    endtask

    task automatic snap();
        s_rd = rd_n; s_wr = wr_n; s_irq = irq_n; s_ack = ack_n; s_log = log_n;
    endtask

    task automatic kick(input logic [31:0] a, input logic sw);
        snap();
        @(posedge clk); #1;
        start = 1'b1; start_addr = a; start_sw = sw;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) begin
            @(posedge clk); #1;
        end
        repeat (2) @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] lg_addr(input int k);
        return log_addr[(s_log + k) % 64];
    endfunction

    function automatic logic [31:0] lg_we(input int k);
        return {31'h0, log_we[(s_log + k) % 64]};
    endfunction

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R11 reset busy", {31'h0, busy}, 0);
        chk("R11 reset err", {31'h0, err}, 0);
        chk("R8 reset end_irq", {31'h0, end_irq}, 0);
        chk("R12 reset mem_valid", {31'h0, mem_valid}, 0);
    endtask

    task automatic t_memcpy();
        put_desc(32'h000, 32'h0000_00A1, 32'h100, 32'h200, 12, 32'h8040_0008, 32'h040);
        for (int i = 0; i < 3; i++) poke(32'h100 + 4 * i, 32'h1122_3344 + 32'h0101_0101 * i);
        kick(32'h000, 1'b1);
        wait_idle();
        for (int k = 0; k < 8; k++) begin
            chk("R1 fetch address", lg_addr(k), 32'(4 * k));
            chk("R1 fetch is read", lg_we(k), 0);
        end
        for (int i = 0; i < 3; i++)
            chk("R9 byte copy", mem[(32'h200 >> 2) + i], 32'h1122_3344 + 32'h0101_0101 * i);
        chk("R6 header cleared", mem[0], 32'h0000_00A0);
        chk("R6 writeback addr", lg_addr(32), 32'h000);
        chk("R6 writeback is write", lg_we(32), 1);
        chk("R7 link fetch after writeback", lg_addr(33), 32'h040);
        chk("R12 read count", 32'(rd_n - s_rd), 28);
        chk("R5 write count", 32'(wr_n - s_wr), 13);
        chk("R8 end pulses", 32'(irq_n - s_irq), 2);
        chk("R9 no ack", 32'(ack_n - s_ack), 0);
    endtask

    task automatic t_fixed_dst();
        put_desc(32'h080, 32'h1, 32'h140, 32'h280, 8, 32'h0022_2000, 32'h0);
        poke(32'h140, 32'hCAFE_0001);
        poke(32'h144, 32'hCAFE_0002);
        poke(32'h284, 32'h5A5A_5A5A);
        kick(32'h080, 1'b1);
        wait_idle();
        chk("R4 src increments", lg_addr(10), 32'h144);
        chk("R4 dst fixed", lg_addr(11), 32'h280);
        chk("R4 fixed dst value", mem[32'h280 >> 2], 32'hCAFE_0002);
        chk("R4 neighbour untouched", mem[32'h284 >> 2], 32'h5A5A_5A5A);
        chk("R5 word beats", 32'(wr_n - s_wr), 3);
        chk("R7 stop without link", 32'(rd_n - s_rd), 10);
        chk("R8 end pulse", 32'(irq_n - s_irq), 1);
    endtask

    task automatic t_ring();
        put_desc(32'h0C0, 32'h1, 32'h180, 32'h300, 4, 32'h8101_1000, 32'h0E0);
        put_desc(32'h0E0, 32'h1, 32'h188, 32'h310, 4, 32'h8011_1000, 32'h0C0);
        poke(32'h180, 32'hBBBB_AAAA);
        poke(32'h188, 32'h0000_DDCC);
        poke(32'h310, 32'h0);
        kick(32'h0C0, 1'b1);
        wait_idle();
        chk("R3 halfword copy", mem[32'h300 >> 2], 32'hBBBB_AAAA);
        chk("R4 src fixed", mem[32'h310 >> 2], 32'hDDCC_DDCC);
        chk("R7 ring stops on consumed", 32'(rd_n - s_rd), 28);
        chk("R6 first header cleared", mem[32'h0C0 >> 2], 0);
        chk("R6 second header cleared", mem[32'h0E0 >> 2], 0);
        chk("R8 masked in chain", 32'(irq_n - s_irq), 2);
    endtask

    task automatic t_invalid();
        put_desc(32'h3C0, 32'h2, 32'h100, 32'h200, 4, 32'h0022_2000, 32'h0);
        kick(32'h3C0, 1'b1);
        wait_idle();
        chk("R2 only fetch reads", 32'(rd_n - s_rd), 8);
        chk("R2 no writes", 32'(wr_n - s_wr), 0);
        chk("R2 end pulse", 32'(irq_n - s_irq), 1);
        chk("R2 no error", {31'h0, err}, 0);
        chk("R2 stopped", {31'h0, busy}, 0);
    endtask

    task automatic t_bad_size();
        put_desc(32'h3E0, 32'h1, 32'h100, 32'h200, 8, 32'h0003_3000, 32'h0);
        kick(32'h3E0, 1'b1);
        wait_idle();
        chk("R3 oversize err", {31'h0, err}, 1);
        chk("R3 oversize no data", 32'(rd_n - s_rd), 8);
        chk("R3 oversize no writes", 32'(wr_n - s_wr), 0);
        poke(32'h3F0, 32'h0001_2000);
        kick(32'h3E0, 1'b1);
        wait_idle();
        chk("R3 mismatch err", {31'h0, err}, 1);
        chk("R3 mismatch no writes", 32'(wr_n - s_wr), 0);
        chk("R3 no end pulse", 32'(irq_n - s_irq), 0);
    endtask

    task automatic t_periph_src();
        put_desc(32'h020, 32'h1, 32'h1A0, 32'h320, 8, 32'h0002_2000, 32'h0);
        poke(32'h1A0, 32'h0102_0304);
        poke(32'h1A4, 32'h0506_0708);
        periph_req = 1'b0;
        kick(32'h020, 1'b0);
        repeat (80) @(posedge clk);
        #1;
        chk("R10 read waits for request", 32'(rd_n - s_rd), 8);
        chk("R10 still busy", {31'h0, busy}, 1);
        periph_req = 1'b1;
        wait_idle();
        periph_req = 1'b0;
        chk("R10 copy word0", mem[32'h320 >> 2], 32'h0102_0304);
        chk("R10 copy word1", mem[32'h324 >> 2], 32'h0506_0708);
        chk("R10 ack per read", 32'(ack_n - s_ack), 2);
    endtask

    task automatic t_periph_dst();
        put_desc(32'h060, 32'h1, 32'h1B0, 32'h330, 4, 32'h0002_2008, 32'h0);
        poke(32'h1B0, 32'h7777_1234);
        periph_req = 1'b0;
        kick(32'h060, 1'b0);
        repeat (80) @(posedge clk);
        #1;
        chk("R10 read not gated", 32'(rd_n - s_rd), 9);
        chk("R10 write waits", 32'(wr_n - s_wr), 0);
        periph_req = 1'b1;
        wait_idle();
        periph_req = 1'b0;
        chk("R10 dst-side copy", mem[32'h330 >> 2], 32'h7777_1234);
        chk("R10 ack per write", 32'(ack_n - s_ack), 1);
    endtask

    task automatic t_error();
        put_desc(32'h0A0, 32'h1, 32'h1C0, 32'h340, 8, 32'h0002_2000, 32'h0);
        err_addr = 32'h1C4;
        kick(32'h0A0, 1'b1);
        wait_idle();
        err_addr = 32'hFFFF_FFFF;
        chk("R11 err set", {31'h0, err}, 1);
        chk("R11 halted", {31'h0, busy}, 0);
        chk("R11 one write only", 32'(wr_n - s_wr), 1);
        chk("R11 no writeback", mem[32'h0A0 >> 2], 1);
        chk("R11 no end pulse", 32'(irq_n - s_irq), 0);
        kick(32'h3C0, 1'b1);
        wait_idle();
        chk("R11 start clears err", {31'h0, err}, 0);
    endtask

    task automatic t_zero_count();
        put_desc(32'h360, 32'h1, 32'h380, 32'h384, 0, 32'h0002_2000, 32'h0);
        kick(32'h360, 1'b1);
        wait_idle();
        chk("R5 zero count no data", 32'(rd_n - s_rd), 8);
        chk("R5 only writeback", 32'(wr_n - s_wr), 1);
        chk("R6 zero count header", mem[32'h360 >> 2], 0);
        chk("R8 zero count end", 32'(irq_n - s_irq), 1);
    endtask

    initial begin
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        t_memcpy();
        t_fixed_dst();
        t_ring();
        t_invalid();
        t_bad_size();
        t_periph_src();
        t_periph_dst();
        t_error();
        t_zero_count();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        $display("FAIL watchdog actual=%0d expected=finish", WD_CYCLES);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail + 1);
        $finish;
    end

endmodule